// File: doc/BRIEF.md
# Triangle-Wave Complementary PWM Timer

This block is a 16-bit timer with a single shared counter and four PWM outputs. In asynchronous (sawtooth) mode the counter climbs to a programmable period value and then wraps to zero. In complementary mode the counter climbs to the period value, falls back to zero and climbs again, so that it traces a triangle wave. Each output has its own duty register and compare point. Each output also has a staging register. The staging value is copied into the duty register only at the period turning point, so a duty change never tears a period in half and a 0% duty can be applied cleanly.

Software works the block through a plain register port: a write strobe, an address and write data, with a combinational read path. The port controls a run bit and the mode bit, loads the period, counter, duty and staging registers, and reads back the count direction and a sticky event flag. At each period event the block emits a one-clock request strobe, which can start an interrupt or a DMA transfer. The period event is the wrap in asynchronous mode and the bottom of the triangle in complementary mode.

Top module: `tri_pwm_timer`

## Requirements
- R1: After reset the counter, period, all duty and staging registers, the control register and the status register read 0, all outputs are low, and `req_o` is low.
- R2: The control register sits at address 0, with bit 0 = run and bit 1 = mode. While run is 0 the counter holds its value. The counter can be written at address 2. Setting run from 0 to 1 makes the counter count upward from its current value, by one per clock, starting one clock after the write.
- R3: In asynchronous mode (mode bit 0) the counter advances to 0 on the clock after it equals the period register (address 1). Otherwise it advances by one.
- R4: In complementary mode (mode bit 1) a counter that is counting up and equals the period register turns to counting down. A counter that is counting down and reaches 0 turns to counting up. Status bit 0 (address 3) reads 1 while the counter counts down.
- R5: In asynchronous mode each output goes high at the wrap (the clock after the period match) and goes low on the clock after the counter equals that output's duty register.
- R6: In complementary mode an output goes low after a compare match made while counting up, and goes high after a compare match made while counting down.
- R7: `req_o` pulses high for one clock after a period event. The period event is a period match in asynchronous mode, or the counter at 0 while counting down in complementary mode. It never pulses while run is 0.
- R8: Status bit 1 is set by every period event and stays set until software writes 1 to that bit. If an event and a clear arrive in the same clock, the set wins.
- R9: Output i has its duty register at address 4+i and its staging register at address 8+i. The staging value moves into the duty register only at a period event. At any other time the duty register changes only by a direct write.
- R10: A staging value of 0 moved in at a period event holds the output low for the whole next period. A 0 written straight into a duty register is replaced by the staging value at the next period event.
- R11: In asynchronous mode status bit 0 always reads 0. The mode bit alone decides which counting and event rules apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW (4) | Register address |
| bus_wdata | input | CW (16) | Write data |
| bus_rdata | output | CW (16) | Read data for `bus_addr`, combinational |
| pwm_o | output | NOUT (4) | PWM outputs |
| req_o | output | 1 | One-clock interrupt/DMA request strobe |

## Verification
A register write takes effect at the rising edge where `bus_we` is sampled. The counter, direction, outputs, `req_o` and the status flag all change at the next rising edge after the condition that drives them, so each result is due exactly one clock after its cause. Read data is combinational from the registers and therefore valid in the same cycle as the address. The bench drives inputs just after a rising edge. It advances a behavioural model at that edge and compares every output and the read data at the falling edge, so each result is checked in the cycle it is due. The directed checks count pulses and levels over windows whose length is a whole number of periods.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
    localparam int REG_CTRL   = 0;
    localparam int REG_CYCLE  = 1;
    localparam int REG_COUNT  = 2;
    localparam int REG_STATUS = 3;
    localparam int DUTY_BASE  = 4;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_MODE_BIT = 1;
    localparam int STAT_DIR_BIT  = 0;
    localparam int STAT_EVT_BIT  = 1;

    typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;
    typedef enum logic {MODE_ASYNC = 1'b0, MODE_COMP = 1'b1} mode_e;
endpackage

// File: rtl/tpwm_counter.sv
module tpwm_counter
    import tpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  mode_e         mode_i,
    input  logic          start_i,
    input  logic [CW-1:0] cycle_i,
    input  logic          ld_i,
    input  logic [CW-1:0] ld_val_i,
    output logic [CW-1:0] cnt_o,
    output dir_e          dir_o,
    output logic          turn_o
);
    localparam logic [CW-1:0] ZERO = '0;
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        dir_e          dir;
    } cnt_st_t;

    cnt_st_t st_q, st_d;
    logic    at_cycle, at_zero;

    always_comb begin
        at_cycle = (st_q.cnt == cycle_i);
        at_zero  = (st_q.cnt == ZERO);
        turn_o   = run_i && (((mode_i == MODE_ASYNC) && at_cycle) ||
                             ((mode_i == MODE_COMP) && (st_q.dir == DIR_DOWN) && at_zero));
        st_d = st_q;
        if (run_i) begin
            if (mode_i == MODE_ASYNC) begin
                st_d.cnt = at_cycle ? ZERO : st_q.cnt + ONE;
            end else if (st_q.dir == DIR_UP) begin
                if (at_cycle) begin
                    st_d.dir = DIR_DOWN;
                    st_d.cnt = at_zero ? ZERO : st_q.cnt - ONE;
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end else begin
                if (at_zero) begin
                    st_d.dir = DIR_UP;
                    st_d.cnt = (cycle_i == ZERO) ? ZERO : ONE;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
        end
        if (mode_i == MODE_ASYNC || start_i) begin
            st_d.dir = DIR_UP;
        end
        if (ld_i) begin
            st_d.cnt = ld_val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: ZERO, dir: DIR_UP};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign dir_o = st_q.dir;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !ld_i) |=> (cnt_o == $past(cnt_o)));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !ld_i && mode_i == MODE_ASYNC && cnt_o != cycle_i)
        |=> (cnt_o == CW'($past(cnt_o) + ONE)));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !ld_i && mode_i == MODE_ASYNC && cnt_o == cycle_i) |=> (cnt_o == ZERO));

    p_turn_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !start_i && mode_i == MODE_COMP && dir_o == DIR_UP && cnt_o == cycle_i)
        |=> (dir_o == DIR_DOWN));

    p_async_up_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_ASYNC) |=> (dir_o == DIR_UP));
endmodule

// File: rtl/tpwm_channel.sv
module tpwm_channel
    import tpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  mode_e         mode_i,
    input  dir_e          dir_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          turn_i,
    input  logic          duty_we_i,
    input  logic          stage_we_i,
    input  logic [CW-1:0] wdata_i,
    output logic [CW-1:0] duty_o,
    output logic [CW-1:0] stage_o,
    output logic          pwm_o
);
    typedef struct packed {
        logic [CW-1:0] duty;
        logic [CW-1:0] stage;
        logic          pwm;
    } ch_st_t;

    ch_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (run_i) begin
            if (turn_i) begin
                st_d.duty = st_q.stage;
                st_d.pwm  = (st_q.stage != '0);
            end else if (cnt_i == st_q.duty) begin
                st_d.pwm = (mode_i == MODE_COMP) && (dir_i == DIR_DOWN);
            end
        end
        if (stage_we_i) begin
            st_d.stage = wdata_i;
        end
        if (duty_we_i) begin
            st_d.duty = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign duty_o  = st_q.duty;
    assign stage_o = st_q.stage;
    assign pwm_o   = st_q.pwm;

    p_duty_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!turn_i && !duty_we_i) |=> (duty_o == $past(duty_o)));

    p_zero_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (turn_i && stage_o == '0 && !duty_we_i) |=> !pwm_o);

    p_start_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (turn_i && stage_o != '0) |=> pwm_o);

    p_down_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !turn_i && mode_i == MODE_COMP && dir_i == DIR_DOWN && cnt_i == duty_o) |=> pwm_o);
endmodule

// File: rtl/tri_pwm_timer.sv
module tri_pwm_timer
    import tpwm_pkg::*;
#(
    parameter int CW   = 16,
    parameter int NOUT = 4,
    parameter int AW   = $clog2(tpwm_pkg::DUTY_BASE + 2 * NOUT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [CW-1:0]   bus_wdata,
    output logic [CW-1:0]   bus_rdata,
    output logic [NOUT-1:0] pwm_o,
    output logic            req_o
);
    localparam int STAGE_BASE = DUTY_BASE + NOUT;

    typedef struct packed {
        logic          run;
        mode_e         mode;
        logic [CW-1:0] cycle;
        logic          flag;
        logic          req;
    } top_st_t;

    top_st_t st_q, st_d;

    logic [CW-1:0] cnt_w;
    dir_e          dir_w;
    logic          turn_w;
    logic          start_w, ld_w;
    logic [CW-1:0] duty_w  [NOUT];
    logic [CW-1:0] stage_w [NOUT];
    logic [NOUT-1:0] duty_we_w, stage_we_w;

    function automatic logic hit(input logic [AW-1:0] a, input int idx);
        return bus_we && (a == AW'(idx));
    endfunction

    always_comb begin
        start_w = hit(bus_addr, REG_CTRL) && bus_wdata[CTRL_RUN_BIT] && !st_q.run;
        ld_w    = hit(bus_addr, REG_COUNT);
        st_d     = st_q;
        st_d.req = turn_w;
        if (hit(bus_addr, REG_CTRL)) begin
            st_d.run  = bus_wdata[CTRL_RUN_BIT];
            st_d.mode = mode_e'(bus_wdata[CTRL_MODE_BIT]);
        end
        if (hit(bus_addr, REG_CYCLE)) begin
            st_d.cycle = bus_wdata;
        end
        if (hit(bus_addr, REG_STATUS) && bus_wdata[STAT_EVT_BIT]) begin
            st_d.flag = 1'b0;
        end
        if (turn_w) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{run: 1'b0, mode: MODE_ASYNC, cycle: '0, flag: 1'b0, req: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    tpwm_counter #(.CW(CW)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (st_q.run),
        .mode_i   (st_q.mode),
        .start_i  (start_w),
        .cycle_i  (st_q.cycle),
        .ld_i     (ld_w),
        .ld_val_i (bus_wdata),
        .cnt_o    (cnt_w),
        .dir_o    (dir_w),
        .turn_o   (turn_w)
    );

    for (genvar i = 0; i < NOUT; i++) begin : g_ch
        assign duty_we_w[i]  = hit(bus_addr, DUTY_BASE + i);
        assign stage_we_w[i] = hit(bus_addr, STAGE_BASE + i);
        tpwm_channel #(.CW(CW)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .run_i      (st_q.run),
            .mode_i     (st_q.mode),
            .dir_i      (dir_w),
            .cnt_i      (cnt_w),
            .turn_i     (turn_w),
            .duty_we_i  (duty_we_w[i]),
            .stage_we_i (stage_we_w[i]),
            .wdata_i    (bus_wdata),
            .duty_o     (duty_w[i]),
            .stage_o    (stage_w[i]),
            .pwm_o      (pwm_o[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(REG_CTRL)) begin
            bus_rdata[CTRL_RUN_BIT]  = st_q.run;
            bus_rdata[CTRL_MODE_BIT] = st_q.mode;
        end
        if (bus_addr == AW'(REG_CYCLE))  bus_rdata = st_q.cycle;
        if (bus_addr == AW'(REG_COUNT))  bus_rdata = cnt_w;
        if (bus_addr == AW'(REG_STATUS)) begin
            bus_rdata[STAT_DIR_BIT] = (dir_w == DIR_DOWN);
            bus_rdata[STAT_EVT_BIT] = st_q.flag;
        end
        for (int i = 0; i < NOUT; i++) begin
            if (bus_addr == AW'(DUTY_BASE + i))  bus_rdata = duty_w[i];
            if (bus_addr == AW'(STAGE_BASE + i)) bus_rdata = stage_w[i];
        end
    end

    assign req_o = st_q.req;

    p_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> st_q.flag);

    p_req_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> $past(st_q.run));
endmodule

// File: tb/tri_pwm_timer_bench.sv
module tri_pwm_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam int NOUT = 4;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [CW-1:0] bus_wdata = '0;
    logic [CW-1:0] bus_rdata;
    logic [NOUT-1:0] pwm_o;
    logic req_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit cmp_en = 1'b0;
    string pwm_tag = "R5";
    string rd_tag = "R3";

    // behavioural reference state
    int m_cnt, m_dir, m_run, m_mode, m_cycle, m_flag, m_req;
    int m_duty[NOUT];
    int m_stage[NOUT];
    int m_pwm[NOUT];

    always #(CLK_PERIOD / 2) clk = ~clk;

    tri_pwm_timer u_tri_pwm_timer (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o), .req_o(req_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_read(input int a);
        if (a == 0) return m_run + 2 * m_mode;
        if (a == 1) return m_cycle;
        if (a == 2) return m_cnt;
        if (a == 3) return m_dir + 2 * m_flag;
        if (a >= 4 && a < 4 + NOUT) return m_duty[a - 4];
        if (a >= 4 + NOUT && a < 4 + 2 * NOUT) return m_stage[a - 4 - NOUT];
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_dir = 0; m_run = 0; m_mode = 0; m_cycle = 0; m_flag = 0; m_req = 0;
            for (int i = 0; i < NOUT; i++) begin
                m_duty[i] = 0; m_stage[i] = 0; m_pwm[i] = 0;
            end
        end else begin
            int event_now, n_cnt, n_dir, a, w;
            a = int'(bus_addr);
            w = int'(bus_wdata);
            event_now = 0;
            n_cnt = m_cnt;
            n_dir = m_dir;
            if (m_run != 0) begin
                if (m_mode == 0) begin
                    event_now = (m_cnt == m_cycle);
                    n_cnt = event_now ? 0 : (m_cnt + 1) % 65536;
                end else if (m_dir == 0) begin
                    if (m_cnt == m_cycle) begin
                        n_dir = 1;
                        n_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
                    end else n_cnt = (m_cnt + 1) % 65536;
                end else begin
                    if (m_cnt == 0) begin
                        event_now = 1;
                        n_dir = 0;
                        n_cnt = (m_cycle == 0) ? 0 : 1;
                    end else n_cnt = m_cnt - 1;
                end
                for (int i = 0; i < NOUT; i++) begin
                    if (event_now != 0) begin
                        m_duty[i] = m_stage[i];
                        m_pwm[i] = (m_stage[i] != 0);
                    end else if (m_cnt == m_duty[i]) begin
                        m_pwm[i] = (m_mode == 1 && m_dir == 1);
                    end
                end
            end
            m_req = event_now;
            if (bus_we && a == 3 && bus_wdata[1]) m_flag = 0;
            if (event_now != 0) m_flag = 1;
            if (bus_we && a == 0) begin
                if (bus_wdata[0] && m_run == 0) n_dir = 0;
                m_run = int'(bus_wdata[0]);
                m_mode = int'(bus_wdata[1]);
            end
            if (m_mode == 0) n_dir = 0;
            if (bus_we && a == 1) m_cycle = w;
            if (bus_we && a == 2) n_cnt = w;
            for (int i = 0; i < NOUT; i++) begin
                if (bus_we && a == 4 + i) m_duty[i] = w;
                if (bus_we && a == 4 + NOUT + i) m_stage[i] = w;
            end
            m_cnt = n_cnt;
            m_dir = n_dir;
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_en && !done) begin
            for (int i = 0; i < NOUT; i++) check(pwm_tag, int'(pwm_o[i]), m_pwm[i]);
            check("R7", int'(req_o), m_req);
            check(rd_tag, int'(bus_rdata), model_read(int'(bus_addr)));
        end
    end

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input int a, input int d);
        bus_we = 1'b1;
        bus_addr = AW'(a);
        bus_wdata = CW'(d);
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        bus_addr = AW'(a);
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int v, highs, pulses, downs;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        for (int a = 0; a < 12; a++) begin
            rd(a, v);
            check("R1", v, 0);
        end
        check("R1", int'(pwm_o), 0);
        check("R1", int'(req_o), 0);
        cmp_en = 1'b1;

        // R2 hold while stopped, then count from current value
        wr(1, 9);
        wr(8, 2); wr(9, 4); wr(10, 0); wr(11, 6);
        wr(2, 5);
        step(3);
        rd(2, v); check("R2", v, 5);
        wr(0, 1);
        rd(2, v); check("R2", v, 5);
        step(1);
        rd(2, v); check("R2", v, 6);

        // R3 / R5 / R7 asynchronous running
        bus_addr = AW'(2);
        step(20);
        pulses = 0; highs = 0; downs = 0;
        for (int k = 0; k < 30; k++) begin
            step(1);
            pulses += int'(req_o);
            highs += int'(pwm_o[2]);
        end
        check("R7", pulses, 3);
        check("R10", highs, 0);
        bus_addr = AW'(3);
        for (int k = 0; k < 20; k++) begin
            step(1);
            downs += int'(bus_rdata[0]);
        end
        check("R11", downs, 0);

        // R10 direct zero duty is replaced at the next event
        wr(7, 0);
        rd(7, v); check("R10", v, 0);
        highs = 0;
        for (int k = 0; k < 20; k++) begin
            step(1);
            highs += int'(pwm_o[3]);
        end
        check("R10", highs > 0 ? 1 : 0, 1);
        rd(7, v); check("R10", v, 6);

        // R9 staging only transfers at a period event; R8 sticky flag
        wr(0, 0);
        wr(8, 7);
        step(5);
        rd(4, v); check("R9", v, 2);
        rd(3, v); check("R8", (v >> 1) & 1, 1);
        wr(3, 2);
        rd(3, v); check("R8", (v >> 1) & 1, 0);
        wr(0, 1);
        step(12);
        rd(4, v); check("R9", v, 7);
        rd(3, v); check("R8", (v >> 1) & 1, 1);

        // complementary mode: R4 / R6 / R7 / R11
        wr(0, 0);
        wr(2, 0);
        pwm_tag = "R6";
        rd_tag = "R4";
        wr(0, 3);
        bus_addr = AW'(3);
        step(20);
        pulses = 0; downs = 0;
        for (int k = 0; k < 36; k++) begin
            step(1);
            pulses += int'(req_o);
            downs += int'(bus_rdata[0]);
        end
        check("R7", pulses, 2);
        check("R4", downs, 18);
        check("R11", downs > 0 ? 1 : 0, 1);
        highs = 0;
        for (int k = 0; k < 36; k++) begin
            step(1);
            highs += int'(pwm_o[2]);
        end
        check("R10", highs, 0);
        wr(0, 2);
        step(4);
        pulses = 0;
        for (int k = 0; k < 20; k++) begin
            step(1);
            pulses += int'(req_o);
        end
        check("R7", pulses, 0);
        finish_run();
    end
endmodule